// File: doc/BRIEF.md
# Three-Bus Multi-Cycle Processor Core

This block is a 32-bit processor that executes one instruction at a time as a sequence of single-register transfers. Two source buses load the ALU operand latches, and a destination bus carries the ALU result to a register. No register-to-register move bypasses the ALU: PC copies, address staging and data moves all pass through it in a copy mode. The core holds a register file, PC, memory address and memory buffer registers, an instruction register and a zero flag. It runs ten instructions: four two-operand ALU operations, invert, register move, load, store, a conditional branch and halt.

Memory is external and word-organised. The core issues one request at a time on a valid/ready channel. It keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until a cycle in which `mem_ready` is high, and that cycle completes the transfer. Once a read is accepted, the core waits for exactly one `mem_rvalid` pulse carrying `mem_rdata`, and it raises no new request until that pulse arrives. It has no response back-pressure: it accepts `mem_rvalid` in any cycle of the wait. A write completes at its handshake and has no response. `halted` is a plain status output.

Top module: `tribus_cpu`

## Requirements
- R1: An active-low reset sets PC to 0, clears the zero flag and clears `halted`. The first request after reset is a read of word 0, raised on the second clock edge after reset is released.
- R2: Each instruction is fetched from word index (PC/4) mod 1024, and PC then advances by 4. Without a branch, successive fetches therefore read consecutive words.
- R3: The instruction word holds the opcode in bits 31:24, source 1 in bits 23:16, source 2 in bits 15:8 and the destination in bits 7:0. A register index is the low five bits of its field. Opcode 0 adds, 1 subtracts (source 1 minus source 2), 3 ANDs, 4 ORs and 2 inverts source 1. Each writes its result to the destination register.
- R4: Opcode 5 copies source 1 to the destination. The zero flag becomes 1 when the written result is zero and 0 otherwise. It is written only by opcodes 0 to 6, never by fetch, address staging, stores or branches.
- R5: Opcode 6 is a load. The next word holds a byte address E. The core reads word (E/4) mod 1024 into the destination register, and PC ends 8 past the load.
- R6: Opcode 7 is a store. It writes source 1 to word (E/4) mod 1024, where E is the next word, and PC ends 8 past the store.
- R7: Opcode 8 is a branch. Bits 23:16 give the condition: 0 always, 1 if the zero flag is set, 2 if it is clear. A taken branch sets PC to the byte address in the next word. A branch not taken continues at PC+8.
- R8: Opcode 9 stops the core. `halted` rises on the second clock edge after the halt word's read response and stays high until reset. No request is raised after the halt word is fetched.
- R9: Opcodes 10 to 255 do nothing, and the next fetch is at PC+4. Condition values 3 to 255 are never taken, and the next fetch is at PC+8.
- R10: A request is held stable while `mem_ready` is low. After a read is accepted, no new request is raised until its `mem_rvalid` pulse.
- R11: Reset does not clear the register file. Values written before a reset are read unchanged by instructions after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | 10 | Word index of the request |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid, one pulse per accepted read |
| mem_rdata | input | 32 | Read data |
| halted | output | 1 | Core has executed a halt |

## Verification
The first request after reset appears after two clock edges. After that, each fetch request appears two edges after the previous instruction finishes, and `halted` is due on the second edge after the halt word's response. The bench drives inputs and samples outputs only on falling edges. It checks the reset timing at those exact edges. For every other request it compares the order, address, direction and data of the accepted requests against a behavioural instruction model, so random ready stalls and response delays of 0 to 2 cycles do not shift what is checked. On every falling edge the bench also compares `halted` against a counter started by the final read response, and checks that a stalled request has not changed.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OPC_ADD  = 8'd0;
  localparam logic [7:0] OPC_SUB  = 8'd1;
  localparam logic [7:0] OPC_NOT  = 8'd2;
  localparam logic [7:0] OPC_AND  = 8'd3;
  localparam logic [7:0] OPC_OR   = 8'd4;
  localparam logic [7:0] OPC_MOV  = 8'd5;
  localparam logic [7:0] OPC_LD   = 8'd6;
  localparam logic [7:0] OPC_ST   = 8'd7;
  localparam logic [7:0] OPC_BR   = 8'd8;
  localparam logic [7:0] OPC_HALT = 8'd9;

  localparam logic [7:0] CND_ALWAYS  = 8'd0;
  localparam logic [7:0] CND_ZERO    = 8'd1;
  localparam logic [7:0] CND_NONZERO = 8'd2;

  typedef enum logic [2:0] {ALU_COPY, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOT} alu_op_e;
  typedef enum logic [2:0] {SRC_NONE, SRC_PC, SRC_MBR, SRC_MAR, SRC_RF} s1_src_e;
  typedef enum logic [2:0] {DST_NONE, DST_MAR, DST_PC, DST_RF, DST_MBR} d_dst_e;

  // One cycle of control: which transfers happen on the three buses.
  typedef struct packed {
    s1_src_e s1;
    logic    s2_b;
    alu_op_e alu;
    d_dst_e  dst;
    logic    flag_en;
    logic    req;
    logic    req_we;
    logic    pc_step;
    logic    ir_ld;
    logic    mbr_ld;
  } uop_t;

  typedef enum logic [4:0] {
    PH_F_A, PH_F_MAR, PH_F_REQ, PH_F_RSP, PH_DEC,
    PH_OP_AB, PH_OP_WB,
    PH_T_A, PH_T_MAR, PH_T_REQ, PH_T_RSP, PH_T_A2, PH_T_MAR2, PH_EXE,
    PH_LD_REQ, PH_LD_RSP, PH_LD_A,
    PH_ST_A, PH_ST_MBR, PH_ST_REQ,
    PH_BR_A, PH_BR_PC,
    PH_HALT
  } phase_e;

  function automatic alu_op_e alu_for(input logic [7:0] opc);
    case (opc)
      OPC_ADD: return ALU_ADD;
      OPC_SUB: return ALU_SUB;
      OPC_AND: return ALU_AND;
      OPC_OR:  return ALU_OR;
      OPC_NOT: return ALU_NOT;
      default: return ALU_COPY;
    endcase
  endfunction
endpackage

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOT: y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/tribus_rf.sv
module tribus_rf #(
  parameter int DEPTH    = 32,
  parameter int W        = 32,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IDX_W-1:0]          waddr,
  input  logic [W-1:0]              wdata,
  input  logic [RD_PORTS*IDX_W-1:0] raddr,
  output logic [RD_PORTS*W-1:0]     rdata
);
  logic [W-1:0] regs [DEPTH];

  // No reset: contents survive a core reset.
  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p*W +: W] = regs[raddr[p*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/tribus_ctrl.sv
module tribus_ctrl
  import tribus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opcode,
  input  logic [7:0] cond,
  input  logic       zflag,
  input  logic       mem_ready,
  input  logic       mem_rvalid,
  output uop_t       uop,
  output logic       halted
);
  phase_e st, nx;
  logic   br_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_F_A;
    else        st <= nx;
  end

  assign halted = (st == PH_HALT);

  always_comb begin
    case (cond)
      CND_ALWAYS:  br_take = 1'b1;
      CND_ZERO:    br_take = zflag;
      CND_NONZERO: br_take = ~zflag;
      default:     br_take = 1'b0;
    endcase
  end

  always_comb begin
    uop = '0;
    nx  = st;
    case (st)
      PH_F_A:   begin uop.s1 = SRC_PC;   nx = PH_F_MAR; end
      PH_F_MAR: begin uop.dst = DST_MAR; nx = PH_F_REQ; end
      PH_F_REQ: begin
        uop.req = 1'b1;
        if (mem_ready) nx = PH_F_RSP;
      end
      PH_F_RSP: if (mem_rvalid) begin
        uop.ir_ld   = 1'b1;
        uop.pc_step = 1'b1;
        nx          = PH_DEC;
      end
      PH_DEC: begin
        case (opcode)
          OPC_ADD, OPC_SUB, OPC_NOT, OPC_AND, OPC_OR, OPC_MOV: nx = PH_OP_AB;
          OPC_LD, OPC_ST, OPC_BR:                              nx = PH_T_A;
          OPC_HALT:                                            nx = PH_HALT;
          default:                                             nx = PH_F_A;
        endcase
      end
      PH_OP_AB: begin uop.s1 = SRC_RF; uop.s2_b = 1'b1; nx = PH_OP_WB; end
      PH_OP_WB: begin
        uop.alu     = alu_for(opcode);
        uop.dst     = DST_RF;
        uop.flag_en = 1'b1;
        nx          = PH_F_A;
      end
      PH_T_A:   begin uop.s1 = SRC_PC;   nx = PH_T_MAR; end
      PH_T_MAR: begin uop.dst = DST_MAR; nx = PH_T_REQ; end
      PH_T_REQ: begin
        uop.req = 1'b1;
        if (mem_ready) nx = PH_T_RSP;
      end
      PH_T_RSP: if (mem_rvalid) begin
        uop.mbr_ld  = 1'b1;
        uop.pc_step = 1'b1;
        nx          = PH_T_A2;
      end
      PH_T_A2:   begin uop.s1 = SRC_MBR;  nx = PH_T_MAR2; end
      PH_T_MAR2: begin uop.dst = DST_MAR; nx = PH_EXE; end
      PH_EXE: begin
        if (opcode == OPC_LD)      nx = PH_LD_REQ;
        else if (opcode == OPC_ST) nx = PH_ST_A;
        else                       nx = br_take ? PH_BR_A : PH_F_A;
      end
      PH_LD_REQ: begin
        uop.req = 1'b1;
        if (mem_ready) nx = PH_LD_RSP;
      end
      PH_LD_RSP: if (mem_rvalid) begin uop.mbr_ld = 1'b1; nx = PH_LD_A; end
      PH_LD_A:   begin uop.s1 = SRC_MBR;  nx = PH_OP_WB; end
      PH_ST_A:   begin uop.s1 = SRC_RF;   nx = PH_ST_MBR; end
      PH_ST_MBR: begin uop.dst = DST_MBR; nx = PH_ST_REQ; end
      PH_ST_REQ: begin
        uop.req    = 1'b1;
        uop.req_we = 1'b1;
        if (mem_ready) nx = PH_F_A;
      end
      PH_BR_A:  begin uop.s1 = SRC_MAR; nx = PH_BR_PC; end
      PH_BR_PC: begin uop.dst = DST_PC; nx = PH_F_A; end
      PH_HALT:  nx = PH_HALT;
      default:  nx = PH_F_A;
    endcase
  end
endmodule

// File: rtl/tribus_cpu.sv
module tribus_cpu
  import tribus_pkg::*;
#(
  parameter int  RF_DEPTH  = 32,
  parameter int  MEM_WORDS = 1024,
  localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int IDX_W = $clog2(RF_DEPTH);

  uop_t              uop;
  logic [WORD_W-1:0] pc, mar, mbr, ir, a_q, b_q;
  logic [WORD_W-1:0] s1_bus, s2_bus, d_bus;
  logic [WORD_W-1:0] rd1;
  logic              zflag;

  tribus_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (ir[31:24]),
    .cond       (ir[23:16]),
    .zflag      (zflag),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .uop        (uop),
    .halted     (halted)
  );

  // Port 0 serves source 1, port 1 serves source 2.
  tribus_rf #(.DEPTH(RF_DEPTH), .W(WORD_W), .RD_PORTS(2)) u_rf (
    .clk   (clk),
    .we    (uop.dst == DST_RF),
    .waddr (ir[IDX_W-1:0]),
    .wdata (d_bus),
    .raddr ({ir[8 +: IDX_W], ir[16 +: IDX_W]}),
    .rdata ({s2_bus, rd1})
  );

  tribus_alu #(.W(WORD_W)) u_alu (
    .op (uop.alu),
    .a  (a_q),
    .b  (b_q),
    .y  (d_bus)
  );

  always_comb begin
    case (uop.s1)
      SRC_PC:  s1_bus = pc;
      SRC_MBR: s1_bus = mbr;
      SRC_MAR: s1_bus = mar;
      SRC_RF:  s1_bus = rd1;
      default: s1_bus = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      zflag <= 1'b0;
      mar   <= '0;
      mbr   <= '0;
      ir    <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      if (uop.s1 != SRC_NONE) a_q <= s1_bus;
      if (uop.s2_b)           b_q <= s2_bus;
      if (uop.ir_ld)          ir  <= mem_rdata;
      if (uop.pc_step)               pc <= pc + 32'd4;
      else if (uop.dst == DST_PC)    pc <= d_bus;
      if (uop.dst == DST_MAR)        mar <= d_bus;
      if (uop.mbr_ld)                mbr <= mem_rdata;
      else if (uop.dst == DST_MBR)   mbr <= d_bus;
      if (uop.flag_en)               zflag <= (d_bus == '0);
    end
  end

  assign mem_valid = uop.req;
  assign mem_we    = uop.req_we;
  assign mem_addr  = mar[ADDR_W+1:2];
  assign mem_wdata = mbr;

  logic unused_bits;
  assign unused_bits = ^{mar[WORD_W-1:ADDR_W+2], mar[1:0],
                         ir[15:8+IDX_W], ir[7:IDX_W]};
endmodule

// File: rtl/tribus_cpu_sva.sv
module tribus_cpu_sva #(
  parameter int  MEM_WORDS = 1024,
  localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_rvalid,
  input logic              halted
);
  logic rd_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  rd_open <= 1'b0;
    else if (mem_valid && mem_ready && !mem_we)  rd_open <= 1'b1;
    else if (mem_rvalid)                         rd_open <= 1'b0;
  end

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_one_read_open: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_valid);

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_valid);

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

bind tribus_cpu tribus_cpu_sva #(.MEM_WORDS(MEM_WORDS)) u_sva (.*);

// File: tb/tribus_cpu_test.sv
`timescale 1ns/1ps
module tribus_cpu_test;
  localparam int MEMW = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid, halted;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  tribus_cpu uut (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .halted(halted)
  );

  typedef struct { bit we; int unsigned addr; logic [31:0] data; string tag; } txn_t;
  txn_t        expq[$];
  logic [31:0] bmem [MEMW];
  logic [31:0] mmem [MEMW];
  logic [31:0] mrf [32];
  string       mtag [32];
  logic [31:0] mpc;
  bit          mz;
  int n_tests = 0, n_fail = 0;
  int halt_arm = -1, pend = -1;
  int unsigned paddr;
  bit read_out = 0, hold = 0, hold_we;
  logic [9:0]  hold_addr;
  logic [31:0] hold_wd;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int s1, input int s2, input int d);
    return {op[7:0], s1[7:0], s2[7:0], d[7:0]};
  endfunction

  task automatic put(input int byte_addr, input logic [31:0] w);
    bmem[byte_addr/4] = w;
    mmem[byte_addr/4] = w;
  endtask

  task automatic push(input bit we, input int unsigned a, input logic [31:0] d, input string tag);
    txn_t t;
    t.we = we; t.addr = a; t.data = d; t.tag = tag;
    expq.push_back(t);
  endtask

  // Behavioural instruction model: lists every memory request in order.
  task automatic model_run();
    string ftag;
    logic [31:0] ir, ea, r;
    int op, s1, s2, d, cnd;
    bit take;
    int unsigned fa, ta, wa;
    ftag = "R1";
    for (int step = 0; step < 400; step++) begin
      fa = (mpc >> 2) % MEMW;
      push(0, fa, 0, ftag);
      ftag = "R2";
      ir = mmem[fa]; mpc += 4;
      op = int'(ir[31:24]); s1 = int'(ir[20:16]); s2 = int'(ir[12:8]);
      d = int'(ir[4:0]); cnd = int'(ir[23:16]);
      if (op == 9) return;
      if (op <= 5) begin
        case (op)
          0: r = mrf[s1] + mrf[s2];
          1: r = mrf[s1] - mrf[s2];
          2: r = ~mrf[s1];
          3: r = mrf[s1] & mrf[s2];
          4: r = mrf[s1] | mrf[s2];
          default: r = mrf[s1];
        endcase
        mrf[d] = r; mz = (r == 0);
        mtag[d] = (op == 5) ? "R4" : "R3";
      end else if (op <= 8) begin
        ta = (mpc >> 2) % MEMW;
        push(0, ta, 0, (op == 6) ? "R5" : (op == 7) ? "R6" : "R7");
        ea = mmem[ta]; mpc += 4;
        wa = (ea >> 2) % MEMW;
        if (op == 6) begin
          push(0, wa, 0, "R5");
          mrf[d] = mmem[wa]; mz = (mrf[d] == 0); mtag[d] = "R5";
        end else if (op == 7) begin
          push(1, wa, mrf[s1], mtag[s1]);
          mmem[wa] = mrf[s1];
        end else begin
          case (cnd)
            0: begin take = 1;   ftag = "R7"; end
            1: begin take = mz;  ftag = "R4"; end
            2: begin take = !mz; ftag = "R4"; end
            default: begin take = 0; ftag = "R9"; end
          endcase
          if (take) mpc = ea;
        end
      end else begin
        ftag = "R9";
      end
    end
  endtask

  task automatic load_prog1();
    for (int i = 0; i < MEMW; i++) put(i*4, 32'h0);
    put(0,   enc(6,0,0,1));  put(4,   800);
    put(8,   enc(6,0,0,2));  put(12,  804);
    put(16,  enc(0,1,2,3));  put(20,  enc(1,1,2,4));
    put(24,  enc(3,1,2,5));  put(28,  enc(4,1,2,6));
    put(32,  enc(2,1,0,7));
    put(36,  enc(7,3,0,0));  put(40,  808);
    put(44,  enc(7,4,0,0));  put(48,  812);
    put(52,  enc(7,5,0,0));  put(56,  816);
    put(60,  enc(7,6,0,0));  put(64,  820);
    put(68,  enc(7,7,0,0));  put(72,  824);
    put(76,  enc(1,1,1,8));
    put(80,  enc(7,8,0,0));  put(84,  828);
    put(88,  enc(8,1,0,0));  put(92,  104);
    put(96,  enc(7,1,0,0));  put(100, 832);
    put(104, enc(5,2,0,9));
    put(108, enc(8,1,0,0));  put(112, 124);
    put(116, enc(8,2,0,0));  put(120, 132);
    put(124, enc(9,0,0,0));
    put(132, enc(8'hAB,1,2,3));
    put(136, enc(8,5,0,0));  put(140, 0);
    put(144, enc(6,0,0,10)); put(148, 836);
    put(152, enc(8,2,0,0));  put(156, 0);
    put(160, enc(8,0,0,0));  put(164, 176);
    put(168, enc(9,0,0,0));
    put(176, enc(5,8'h21,0,11));
    put(180, enc(7,11,0,0)); put(184, 840);
    put(188, enc(1,1,1,13));
    put(192, enc(9,0,0,0));
    put(800, 32'd7); put(804, 32'd5);
  endtask

  task automatic load_prog2();
    put(0,  enc(8,1,0,0));  put(4,  100);
    put(8,  enc(7,3,0,0));  put(12, 900);
    put(16, enc(0,3,6,12));
    put(20, enc(7,12,0,0)); put(24, 904);
    put(28, enc(9,0,0,0));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Memory responder and per-clock comparison, all on falling edges.
  initial begin
    mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (halt_arm >= 0) halt_arm++;
      check(halted === (halt_arm >= 2), "R8", "halted level", 32'(halted), 32'(halt_arm >= 2));
      if (hold)
        check(mem_valid && mem_we == hold_we && mem_addr == hold_addr && mem_wdata == hold_wd,
              "R10", "stalled request changed", {mem_we, 21'b0, mem_addr}, {hold_we, 21'b0, hold_addr});
      if (read_out && mem_valid)
        check(0, "R10", "request while read open", 32'd1, 32'd0);
      if (pend == 0) begin
        mem_rvalid = 1; mem_rdata = bmem[paddr];
        read_out = 0; pend = -1;
        if (expq.size() == 0) halt_arm = 0;
      end else if (pend > 0) begin
        pend--;
      end
      mem_ready = ($urandom_range(0, 3) != 0);
      hold = 0;
      if (mem_valid && !read_out) begin
        if (mem_ready) begin
          if (expq.size() == 0) begin
            check(0, "R8", "request after halt", 32'(mem_addr), 32'd0);
          end else begin
            txn_t e;
            e = expq.pop_front();
            check(mem_we == e.we && 32'(mem_addr) == e.addr, e.tag, "request addr/dir",
                  {mem_we, 21'b0, mem_addr}, {e.we, 21'b0, e.addr[9:0]});
            if (e.we)
              check(mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
          end
          if (mem_we) bmem[mem_addr] = mem_wdata;
          else begin
            pend = $urandom_range(0, 2); paddr = mem_addr; read_out = 1;
          end
        end else begin
          hold = 1; hold_we = mem_we; hold_addr = mem_addr; hold_wd = mem_wdata;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=halted");
    finish_run();
  end

  task automatic wait_halt();
    while (!(halt_arm >= 2 && halted)) @(negedge clk);
    repeat (12) @(negedge clk);
    check(expq.size() == 0, "R8", "requests left unissued", 32'(expq.size()), 32'd0);
  endtask

  initial begin
    mpc = 0; mz = 0;
    for (int i = 0; i < 32; i++) mtag[i] = "R6";
    load_prog1();
    model_run();
    repeat (3) @(negedge clk);
    check(!halted, "R1", "halted in reset", 32'(halted), 32'd0);
    check(!mem_valid, "R1", "request in reset", 32'(mem_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check(!mem_valid, "R1", "request one edge after reset", 32'(mem_valid), 32'd0);
    @(negedge clk);
    check(mem_valid && !mem_we && mem_addr == 0, "R1", "first fetch two edges after reset",
          {mem_valid, 21'b0, mem_addr}, {1'b1, 31'd0});
    wait_halt();

    // Second run: R11 register contents carried across reset, R1 flag cleared.
    @(posedge clk); #5;
    rst_n = 0; halt_arm = -1;
    mpc = 0; mz = 0;
    for (int i = 0; i < 32; i++) mtag[i] = "R11";
    load_prog2();
    model_run();
    repeat (2) @(negedge clk);
    check(!halted, "R1", "halted cleared by reset", 32'(halted), 32'd0);
    rst_n = 1;
    wait_halt();
    finish_run();
  end
endmodule